// File: doc/BRIEF.md
# Scan Interrupt Source Localizer

This block finds which instrument raised an interrupt in a hierarchical scan network. The network carries bypassable interrupt flag bits in front of each section. When a request arrives, the block puts the network into localization mode. It then runs a single capture-shift-update pass through a TAP sequencer. Each flag bit that comes back steers a walk over a flattened model of the network, held in a model ROM. A 0 jumps over the section the flag guards, and a 1 descends into it. The walk stops when it lands on a leaf instrument register right after an entered flag. It also stops if it runs off the end of the array.

The leaf's array index addresses a vector ROM. The handler address read there goes to the processor side with a one-cycle valid strobe. Requests come in two classes. An urgent request first asks the processor to halt and waits for it to confirm that its state is saved. A deferrable request waits until the processor reports that its current periodic job is idle. A request that arrives while a search is running stays pending until that search ends.

Top module: `irq_localizer`

## Requirements
- R1: `loc_o` rises when a search starts and falls only in the cycle after the sequencer reports `seq_done_i`. `seq_shift_o` is never high while `loc_o` is low, and `loc_o` is low once a result has been delivered.
- R2: Each search issues exactly one `seq_start_o` pulse and exactly one `seq_end_o` pulse.
- R3: Each model ROM word holds the entry kind in its top two bits and a skip index in its low bits. The kind codes are 0 for a plain register, 1 for a flag and 2 for a leaf. The walk starts at index 0 and passes over plain entries. At a flag it requests one bit: a 1 moves to the next index, and a 0 moves to the flag's skip index.
- R4: A leaf entry met right after an entered flag ends the walk. Its index is driven on `vrom_addr_o`. The vector ROM word appears on `vec_o` with `vec_vld_o` high for exactly one cycle.
- R5: If the walk reaches index N_ENT, or a flag's skip index is not beyond the flag, the search ends with a one-cycle `err_o` pulse and no `vec_vld_o`.
- R6: An urgent request raises `halt_o` before the search. `loc_o` stays low until `halt_ack_i` is high. `halt_o` stays high until the cycle in which the result strobe appears, and `vec_pre_o` is 1 with that result.
- R7: A deferrable request starts no search while `proc_idle_i` is low. It never raises `halt_o`, and it delivers `vec_pre_o` = 0.
- R8: When both classes are pending, the urgent one is serviced first.
- R9: A request that arrives while a search is running is kept and serviced after the current result.
- R10: The number of bits shifted in one search equals the number of flags visited on the path to the leaf, or to the array end. No bit is requested after the walk has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pi_req_i | input | 1 | Urgent interrupt request pulse |
| npi_req_i | input | 1 | Deferrable interrupt request pulse |
| proc_idle_i | input | 1 | Processor has finished its periodic job |
| halt_ack_i | input | 1 | Processor halted and state saved |
| halt_o | output | 1 | Request to stop the processor |
| loc_o | output | 1 | Localization mode control toward the network |
| seq_start_o | output | 1 | Start the capture-shift-update pass |
| seq_shift_o | output | 1 | Request one shifted-out bit |
| seq_bit_vld_i | input | 1 | Shifted bit is valid |
| seq_bit_i | input | 1 | Shifted-out flag value |
| seq_end_o | output | 1 | End shifting and perform update |
| seq_done_i | input | 1 | Update phase complete |
| mrom_addr_o | output | IDXW | Model ROM index |
| mrom_data_i | input | IDXW+2 | Model ROM word {kind, skip} |
| vrom_addr_o | output | IDXW | Vector ROM index (leaf index) |
| vrom_data_i | input | VEC_W | Handler address |
| vec_o | output | VEC_W | Handler address result |
| vec_vld_o | output | 1 | One-cycle result strobe |
| vec_pre_o | output | 1 | Result belongs to an urgent request |
| err_o | output | 1 | One-cycle no-leaf-found strobe |

## Verification
Two events can land on the same clock edge. One is a pending request being taken into service. The other is a fresh request, of the same or the other class, being recorded. The bench raises both request lines in one cycle and holds the halt acknowledge low. It then checks that the urgent result arrives first with its class flag set, and that the deferrable search still runs afterwards without a halt. A second test pulses a deferrable request while an urgent search is shifting. That request must yield a second full search with its own start and end pulses.

// File: rtl/irqloc_pkg.sv
package irqloc_pkg;

    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_FLAG  = 2'd1,
        KIND_LEAF  = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ARB_IDLE,
        ARB_HALT,
        ARB_RUN
    } arb_st_e;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_SEEK,
        WK_BIT,
        WK_END,
        WK_WAIT
    } wk_st_e;

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irqloc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pi_req_i,
    input  logic npi_req_i,
    input  logic proc_idle_i,
    input  logic halt_ack_i,
    input  logic done_i,
    output logic go_o,
    output logic cls_pre_o,
    output logic halt_o
);

    typedef struct packed {
        arb_st_e st;
        logic    pend_pi;
        logic    pend_npi;
        logic    go;
        logic    pre;
        logic    halt;
    } arb_t;

    arb_t q, d;
    logic take_pi, take_npi;

    always_comb begin
        d        = q;
        d.go     = 1'b0;
        take_pi  = 1'b0;
        take_npi = 1'b0;
        case (q.st)
            ARB_IDLE: begin
                if (q.pend_pi) begin
                    take_pi = 1'b1;
                    d.st    = ARB_HALT;
                    d.halt  = 1'b1;
                    d.pre   = 1'b1;
                end else if (q.pend_npi && proc_idle_i) begin
                    take_npi = 1'b1;
                    d.st     = ARB_RUN;
                    d.go     = 1'b1;
                    d.pre    = 1'b0;
                end
            end
            ARB_HALT: begin
                if (halt_ack_i) begin
                    d.go = 1'b1;
                    d.st = ARB_RUN;
                end
            end
            ARB_RUN: begin
                if (done_i) begin
                    d.st   = ARB_IDLE;
                    d.halt = 1'b0;
                end
            end
            default: d.st = ARB_IDLE;
        endcase
        d.pend_pi  = (q.pend_pi  & ~take_pi)  | pi_req_i;
        d.pend_npi = (q.pend_npi & ~take_npi) | npi_req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ARB_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign go_o      = q.go;
    assign cls_pre_o = q.pre;
    assign halt_o    = q.halt;

    // R6
    pre_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_o && cls_pre_o) |-> halt_o);

    // R7
    npi_nohalt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ARB_RUN && !q.pre) |-> !halt_o);

endmodule

// File: rtl/scan_walker.sv
module scan_walker
    import irqloc_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int IDXW  = $clog2(N_ENT + 1),
    parameter int ENT_W = IDXW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    output logic [IDXW-1:0]  mrom_addr_o,
    input  logic [ENT_W-1:0] mrom_data_i,
    output logic             loc_o,
    output logic             seq_start_o,
    output logic             seq_shift_o,
    input  logic             seq_bit_vld_i,
    input  logic             seq_bit_i,
    output logic             seq_end_o,
    input  logic             seq_done_i,
    output logic             done_o,
    output logic             found_o,
    output logic [IDXW-1:0]  leaf_o
);

    localparam logic [IDXW-1:0] END_IDX = IDXW'(N_ENT);

    typedef struct packed {
        wk_st_e          st;
        logic [IDXW-1:0] idx;
        logic            entered;
        logic            loc;
        logic            start;
        logic            shift;
        logic            fin;
        logic            done;
        logic            found;
        logic [IDXW-1:0] leaf;
    } wk_t;

    wk_t q, d;
    kind_e           ent_kind;
    logic [IDXW-1:0] ent_skip;
    logic            at_end;

    assign ent_kind = kind_e'(mrom_data_i[ENT_W-1 -: 2]);
    assign ent_skip = mrom_data_i[IDXW-1:0];
    assign at_end   = (q.idx >= END_IDX);

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.fin   = 1'b0;
        d.done  = 1'b0;
        case (q.st)
            WK_IDLE: begin
                if (go_i) begin
                    d.st      = WK_SEEK;
                    d.idx     = '0;
                    d.entered = 1'b0;
                    d.loc     = 1'b1;
                    d.start   = 1'b1;
                    d.found   = 1'b0;
                end
            end
            WK_SEEK: begin
                if (at_end) begin
                    d.found = 1'b0;
                    d.st    = WK_END;
                end else begin
                    case (ent_kind)
                        KIND_FLAG: begin
                            d.st    = WK_BIT;
                            d.shift = 1'b1;
                        end
                        KIND_LEAF: begin
                            if (q.entered) begin
                                d.found = 1'b1;
                                d.leaf  = q.idx;
                                d.st    = WK_END;
                            end else begin
                                d.idx     = q.idx + 1'b1;
                                d.entered = 1'b0;
                            end
                        end
                        default: begin
                            d.idx     = q.idx + 1'b1;
                            d.entered = 1'b0;
                        end
                    endcase
                end
            end
            WK_BIT: begin
                if (seq_bit_vld_i) begin
                    d.shift = 1'b0;
                    if (seq_bit_i) begin
                        d.idx     = q.idx + 1'b1;
                        d.entered = 1'b1;
                        d.st      = WK_SEEK;
                    end else if (ent_skip > q.idx) begin
                        d.idx     = ent_skip;
                        d.entered = 1'b0;
                        d.st      = WK_SEEK;
                    end else begin
                        d.found = 1'b0;
                        d.st    = WK_END;
                    end
                end
            end
            WK_END: begin
                d.fin = 1'b1;
                d.st  = WK_WAIT;
            end
            WK_WAIT: begin
                if (seq_done_i) begin
                    d.loc  = 1'b0;
                    d.done = 1'b1;
                    d.st   = WK_IDLE;
                end
            end
            default: d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: WK_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign mrom_addr_o = q.idx;
    assign loc_o       = q.loc;
    assign seq_start_o = q.start;
    assign seq_shift_o = q.shift;
    assign seq_end_o   = q.fin;
    assign done_o      = q.done;
    assign found_o     = q.found;
    assign leaf_o      = q.leaf;

    // R1
    shift_in_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_shift_o |-> loc_o);

    // R1
    loc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(loc_o) |-> $past(seq_done_i));

    // R2
    start_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start_o |-> (loc_o && !seq_shift_o));

    // R10
    no_shift_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_end_o |-> !seq_shift_o);

endmodule

// File: rtl/vec_stage.sv
module vec_stage #(
    parameter int IDXW  = 5,
    parameter int VEC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic             found_i,
    input  logic [IDXW-1:0]  leaf_i,
    input  logic             pre_i,
    output logic [IDXW-1:0]  vrom_addr_o,
    input  logic [VEC_W-1:0] vrom_data_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_vld_o,
    output logic             vec_pre_o,
    output logic             err_o
);

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic             vld;
        logic             pre;
        logic             err;
    } vs_t;

    vs_t q, d;

    assign vrom_addr_o = leaf_i;

    always_comb begin
        d     = q;
        d.vld = done_i & found_i;
        d.err = done_i & ~found_i;
        if (done_i) begin
            d.pre = pre_i;
            if (found_i) begin
                d.vec = vrom_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign vec_o     = q.vec;
    assign vec_vld_o = q.vld;
    assign vec_pre_o = q.pre;
    assign err_o     = q.err;

    // R4
    vec_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |=> !vec_vld_o);

    // R5
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !vec_vld_o);

endmodule

// File: rtl/irq_localizer.sv
module irq_localizer #(
    parameter int N_ENT = 16,
    parameter int VEC_W = 16,
    localparam int IDXW  = $clog2(N_ENT + 1),
    localparam int ENT_W = IDXW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pi_req_i,
    input  logic             npi_req_i,
    input  logic             proc_idle_i,
    input  logic             halt_ack_i,
    output logic             halt_o,
    output logic             loc_o,
    output logic             seq_start_o,
    output logic             seq_shift_o,
    input  logic             seq_bit_vld_i,
    input  logic             seq_bit_i,
    output logic             seq_end_o,
    input  logic             seq_done_i,
    output logic [IDXW-1:0]  mrom_addr_o,
    input  logic [ENT_W-1:0] mrom_data_i,
    output logic [IDXW-1:0]  vrom_addr_o,
    input  logic [VEC_W-1:0] vrom_data_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_vld_o,
    output logic             vec_pre_o,
    output logic             err_o
);

    logic            go;
    logic            cls_pre;
    logic            walk_done;
    logic            walk_found;
    logic [IDXW-1:0] walk_leaf;

    irq_arbiter u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .pi_req_i    (pi_req_i),
        .npi_req_i   (npi_req_i),
        .proc_idle_i (proc_idle_i),
        .halt_ack_i  (halt_ack_i),
        .done_i      (walk_done),
        .go_o        (go),
        .cls_pre_o   (cls_pre),
        .halt_o      (halt_o)
    );

    scan_walker #(
        .N_ENT (N_ENT),
        .IDXW  (IDXW),
        .ENT_W (ENT_W)
    ) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .go_i          (go),
        .mrom_addr_o   (mrom_addr_o),
        .mrom_data_i   (mrom_data_i),
        .loc_o         (loc_o),
        .seq_start_o   (seq_start_o),
        .seq_shift_o   (seq_shift_o),
        .seq_bit_vld_i (seq_bit_vld_i),
        .seq_bit_i     (seq_bit_i),
        .seq_end_o     (seq_end_o),
        .seq_done_i    (seq_done_i),
        .done_o        (walk_done),
        .found_o       (walk_found),
        .leaf_o        (walk_leaf)
    );

    vec_stage #(
        .IDXW  (IDXW),
        .VEC_W (VEC_W)
    ) u_vec (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_i      (walk_done),
        .found_i     (walk_found),
        .leaf_i      (walk_leaf),
        .pre_i       (cls_pre),
        .vrom_addr_o (vrom_addr_o),
        .vrom_data_i (vrom_data_i),
        .vec_o       (vec_o),
        .vec_vld_o   (vec_vld_o),
        .vec_pre_o   (vec_pre_o),
        .err_o       (err_o)
    );

    // R6
    result_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_vld_o || err_o) |-> !loc_o);

endmodule

// File: tb/irq_localizer_bench.sv
`timescale 1ns/1ps
module irq_localizer_bench;

    localparam int N_ENT = 16;
    localparam int IDXW  = 5;
    localparam int ENT_W = 7;
    localparam int VEC_W = 16;

    // network model: {kind, skip}; kind 0 plain, 1 flag, 2 leaf
    localparam logic [ENT_W-1:0] MODEL [N_ENT] = '{
        {2'd0, 5'd0},  {2'd1, 5'd7},  {2'd1, 5'd4},  {2'd2, 5'd0},
        {2'd0, 5'd0},  {2'd1, 5'd7},  {2'd2, 5'd0},  {2'd1, 5'd9},
        {2'd2, 5'd0},  {2'd1, 5'd16}, {2'd0, 5'd0},  {2'd1, 5'd14},
        {2'd1, 5'd14}, {2'd2, 5'd0},  {2'd1, 5'd16}, {2'd2, 5'd0}
    };

    // {pre, target, flag bits, vector, err}
    localparam int NROW = 6;
    localparam logic [26:0] ROWS [NROW] = '{
        {1'b1, 5'd3,  4'd2, 16'hA00C, 1'b0},
        {1'b0, 5'd6,  4'd3, 16'hA018, 1'b0},
        {1'b1, 5'd8,  4'd2, 16'hA020, 1'b0},
        {1'b0, 5'd13, 4'd5, 16'hA034, 1'b0},
        {1'b1, 5'd15, 4'd5, 16'hA03C, 1'b0},
        {1'b0, 5'd0,  4'd3, 16'h0000, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pi_req = 1'b0, npi_req = 1'b0, proc_idle = 1'b1, halt_ack = 1'b0;
    logic halt, loc, seq_start, seq_shift, seq_end;
    logic seq_bit_vld = 1'b0, seq_bit = 1'b0, seq_done = 1'b0;
    logic [IDXW-1:0]  mrom_addr, vrom_addr;
    logic [ENT_W-1:0] mrom_data;
    logic [VEC_W-1:0] vrom_data, vec;
    logic vec_vld, vec_pre, err;

    logic [IDXW-1:0] tgt = '0;
    int checks = 0, errors = 0;
    int start_cnt = 0, end_cnt = 0, bit_cnt = 0, halt_rise = 0;
    logic halt_prev = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign mrom_data = (mrom_addr < IDXW'(N_ENT)) ? MODEL[mrom_addr[3:0]] : '0;
    assign vrom_data = 16'hA000 | {9'd0, vrom_addr, 2'b00};

    irq_localizer u_irq_localizer (
        .clk (clk), .rst_n (rst_n),
        .pi_req_i (pi_req), .npi_req_i (npi_req),
        .proc_idle_i (proc_idle), .halt_ack_i (halt_ack),
        .halt_o (halt), .loc_o (loc),
        .seq_start_o (seq_start), .seq_shift_o (seq_shift),
        .seq_bit_vld_i (seq_bit_vld), .seq_bit_i (seq_bit),
        .seq_end_o (seq_end), .seq_done_i (seq_done),
        .mrom_addr_o (mrom_addr), .mrom_data_i (mrom_data),
        .vrom_addr_o (vrom_addr), .vrom_data_i (vrom_data),
        .vec_o (vec), .vec_vld_o (vec_vld), .vec_pre_o (vec_pre), .err_o (err)
    );

    // sequencer and network model, driven away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            seq_bit_vld <= 1'b0;
            seq_bit     <= 1'b0;
            seq_done    <= 1'b0;
        end else begin
            seq_bit_vld <= 1'b0;
            seq_bit     <= 1'b0;
            seq_done    <= seq_end;
            if (seq_shift && !seq_bit_vld && mrom_addr < IDXW'(N_ENT)) begin
                seq_bit_vld <= 1'b1;
                seq_bit     <= (tgt > mrom_addr) && (tgt < MODEL[mrom_addr[3:0]][IDXW-1:0]);
            end
        end
    end

    always @(posedge clk) begin
        if (seq_start) start_cnt <= start_cnt + 1;
        if (seq_end) end_cnt <= end_cnt + 1;
        if (seq_bit_vld && seq_shift) bit_cnt <= bit_cnt + 1;
        if (halt && !halt_prev) halt_rise <= halt_rise + 1;
        halt_prev <= halt;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_result(output bit got_v, output bit got_e, output logic [15:0] v, output bit p, output bit h);
        bit seen = 1'b0;
        got_v = 1'b0; got_e = 1'b0; v = '0; p = 1'b0; h = 1'b0;
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk);
            if (vec_vld || err) begin
                seen  = 1'b1;
                got_v = vec_vld; got_e = err; v = vec; p = vec_pre; h = halt;
            end
        end
        chk(seen, "R4 result arrives", 32'(seen), 1);
    endtask

    task automatic pulse_req(input bit pre, input bit npi);
        @(negedge clk);
        pi_req = pre; npi_req = npi;
        @(negedge clk);
        pi_req = 1'b0; npi_req = 1'b0;
    endtask

    task automatic wait_halt();
        for (int i = 0; i < 30 && !halt; i++) @(negedge clk);
    endtask

    task automatic run_row(input logic [26:0] row);
        bit pre, gv, ge, gp, gh;
        logic [15:0] gvec;
        int s0, e0, b0, h0;
        pre = row[26];
        tgt = row[25:21];
        s0 = start_cnt; e0 = end_cnt; b0 = bit_cnt; h0 = halt_rise;
        pulse_req(pre, !pre);
        if (pre) begin
            wait_halt();
            chk(halt == 1'b1, "R6 halt raised", 32'(halt), 1);
            repeat (4) @(negedge clk);
            chk(loc == 1'b0, "R6 no search before ack", 32'(loc), 0);
            halt_ack = 1'b1;
        end
        wait_result(gv, ge, gvec, gp, gh);
        halt_ack = 1'b0;
        chk(gv == !row[0], "R4 valid strobe", 32'(gv), 32'(!row[0]));
        chk(ge == row[0], "R5 error strobe", 32'(ge), 32'(row[0]));
        if (!row[0]) chk(gvec == row[16:1], "R4 vector value", 32'(gvec), 32'(row[16:1]));
        chk(gp == pre, "R6 R7 class flag", 32'(gp), 32'(pre));
        chk(gh == 1'b0, "R6 halt released with result", 32'(gh), 0);
        chk(loc == 1'b0, "R1 loc low after result", 32'(loc), 0);
        chk(bit_cnt - b0 == int'(row[20:17]), "R3 R10 flag bits shifted", 32'(bit_cnt - b0), 32'(row[20:17]));
        chk(start_cnt - s0 == 1 && end_cnt - e0 == 1, "R2 one start one end",
            32'((start_cnt - s0) * 16 + (end_cnt - e0)), 32'h11);
        if (!pre) chk(halt_rise == h0, "R7 no halt", 32'(halt_rise - h0), 0);
        @(negedge clk);
        chk(!vec_vld && !err, "R4 R5 strobe one cycle", 32'({vec_vld, err}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit gv, ge, gp, gh;
        logic [15:0] gvec;
        int s0, h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!loc && !halt && !vec_vld && !err && !seq_shift, "R1 reset state",
            32'({loc, halt, vec_vld, err, seq_shift}), 0);

        for (int r = 0; r < NROW; r++) run_row(ROWS[r]);

        // R7: deferrable request waits for the idle report
        proc_idle = 1'b0;
        tgt = 5'd8;
        s0 = start_cnt; h0 = halt_rise;
        pulse_req(1'b0, 1'b1);
        repeat (15) @(negedge clk);
        chk(loc == 1'b0 && start_cnt == s0, "R7 waits for idle", 32'(loc), 0);
        proc_idle = 1'b1;
        wait_result(gv, ge, gvec, gp, gh);
        chk(gv && gvec == 16'hA020, "R7 serviced after idle", 32'(gvec), 32'hA020);
        chk(halt_rise == h0, "R7 halt untouched", 32'(halt_rise - h0), 0);

        // R8: both classes in the same cycle
        tgt = 5'd13;
        s0 = start_cnt; h0 = halt_rise;
        pulse_req(1'b1, 1'b1);
        wait_halt();
        repeat (3) @(negedge clk);
        chk(loc == 1'b0 && start_cnt == s0, "R8 urgent first, held for ack", 32'(loc), 0);
        halt_ack = 1'b1;
        wait_result(gv, ge, gvec, gp, gh);
        halt_ack = 1'b0;
        chk(gp == 1'b1 && gvec == 16'hA034, "R8 urgent result first", 32'({gp, gvec}), 32'h1A034);
        wait_result(gv, ge, gvec, gp, gh);
        chk(gp == 1'b0 && gv, "R8 deferrable result second", 32'(gp), 0);
        chk(halt_rise == h0 + 1, "R8 single halt", 32'(halt_rise - h0), 1);

        // R9: request arriving mid-search is kept
        tgt = 5'd3;
        s0 = start_cnt;
        halt_ack = 1'b1;
        pulse_req(1'b1, 1'b0);
        for (int i = 0; i < 30 && !loc; i++) @(negedge clk);
        npi_req = 1'b1;
        @(negedge clk);
        npi_req = 1'b0;
        wait_result(gv, ge, gvec, gp, gh);
        halt_ack = 1'b0;
        chk(gp == 1'b1 && gvec == 16'hA00C, "R9 current search completes", 32'({gp, gvec}), 32'h1A00C);
        wait_result(gv, ge, gvec, gp, gh);
        chk(gp == 1'b0 && gvec == 16'hA00C, "R9 pending serviced after", 32'({gp, gvec}), 32'hA00C);
        chk(start_cnt - s0 == 2, "R9 two searches", 32'(start_cnt - s0), 2);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule